// File: doc/BRIEF.md
# Edge-Counting Frequency Divider Channel

This timer channel divides an external, asynchronous input signal by a programmable ratio. The input is brought into the system clock domain through a two-flop synchronizer. It then optionally passes a short noise filter. An edge detector qualifies rising edges, falling edges or both, depending on a select field. Each qualified edge steps a reloadable down counter. Each time the counter has run out, the output pin toggles and a one-cycle interrupt pulse is raised.

After a start strobe the channel waits for the first qualified edge. That edge only loads the counter from the reload register. A mode bit chooses whether this load edge also toggles the output and raises the interrupt. Software may write the reload register at any time, and a written value only applies from the next reload. A stop strobe freezes the channel, and the output keeps its level. With reload value N the output half-period is N+1 qualified edges. With a single edge mode the output frequency is therefore the input frequency divided by 2(N+1). In both-edge mode it is roughly the input frequency divided by N+1. Because the input is sampled, each output edge may be off by up to one clock period.

Top module: `freq_div_chan`

## Requirements
- R1: During reset and after it, `pin_out` and `irq_o` are 0 and the reload value is 0.
- R2: Before the first start strobe, input edges have no effect. After a start with `start_tgl`=0, the first qualified edge loads the counter without toggling `pin_out` and without an interrupt.
- R3: After a start with `start_tgl`=1, the first qualified edge loads the counter, toggles `pin_out` and raises one interrupt pulse.
- R4: With `edge_sel`=2'b00 only rising input edges are counted. With reload value N, `pin_out` toggles once every N+1 rising edges after the load edge.
- R5: With `edge_sel`=2'b01 only falling input edges are counted, with the same N+1 spacing.
- R6: With `edge_sel`=2'b10 or 2'b11 every input edge is counted, with the same N+1 spacing.
- R7: `irq_o` is high for exactly one clock cycle each time `pin_out` changes, and at no other time.
- R8: A reload write (`rld_we`=1) during a period does not change that period. The written value sets the length of the periods that start from the next reload on.
- R9: With `filt_en`=1, an input pulse that lasts one clock cycle is ignored. A level that stays stable for two or more samples is accepted.
- R10: With `filt_en`=0, an input pulse that lasts one clock cycle is seen as an edge.
- R11: After a `stop_i` strobe no edge is counted and `pin_out` keeps its level. A later `start_i` waits for a new load edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_in | input | 1 | Asynchronous input signal to be divided |
| start_i | input | 1 | Start strobe; arms the channel to wait for a load edge |
| stop_i | input | 1 | Stop strobe; halts counting |
| edge_sel | input | 2 | 00 rising, 01 falling, 1x both edges |
| filt_en | input | 1 | Enables the two-sample noise filter |
| start_tgl | input | 1 | When 1, the load edge also toggles and interrupts |
| rld_we | input | 1 | Reload register write enable |
| rld_wdata | input | W | Reload value to be written |
| pin_out | output | 1 | Divided output |
| irq_o | output | 1 | One-cycle pulse at every output toggle |

## Verification
The divider is driven with slow square waves in each of the three edge modes. This shows whether the counter picks the correct edge polarity and whether the toggle spacing is N+1 edges rather than N or N+2. One-cycle glitches are applied with the filter on and with it off, which shows whether the filter rejects short pulses without also losing real edges. Reload writes in the middle of a period, stop and restart, and both start modes are combined with random reload values and random input hold times. Together they show whether the load edge, the deferred reload and the held output level behave correctly.

// File: rtl/freq_div_chan.sv
module freq_div_chan #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         pin_in,
  input  logic         start_i,
  input  logic         stop_i,
  input  logic [1:0]   edge_sel,
  input  logic         filt_en,
  input  logic         start_tgl,
  input  logic         rld_we,
  input  logic [W-1:0] rld_wdata,
  output logic         pin_out,
  output logic         irq_o
);

  logic         s1, s2, s3, lvl, lvl_d;
  logic         run_q, armed_q;
  logic [W-1:0] cnt_q, rld_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= 1'b0; s2 <= 1'b0; s3 <= 1'b0;
      lvl <= 1'b0; lvl_d <= 1'b0;
    end else begin
      s1 <= pin_in;
      s2 <= s1;
      s3 <= s2;
      if (!filt_en || (s2 == s3)) lvl <= s2;
      lvl_d <= lvl;
    end
  end

  wire rise  = lvl & ~lvl_d;
  wire fall  = ~lvl & lvl_d;
  wire valid = edge_sel[1] ? (rise | fall) : (edge_sel[0] ? fall : rise);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rld_q <= '0;
    else if (rld_we) rld_q <= rld_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q   <= 1'b0;
      armed_q <= 1'b0;
      cnt_q   <= '0;
      pin_out <= 1'b0;
      irq_o   <= 1'b0;
    end else begin
      irq_o <= 1'b0;
      if (start_i) begin
        run_q   <= 1'b1;
        armed_q <= 1'b0;
      end else if (stop_i) begin
        run_q <= 1'b0;
      end else if (run_q && valid) begin
        if (!armed_q) begin
          armed_q <= 1'b1;
          cnt_q   <= rld_q;
          if (start_tgl) begin
            pin_out <= ~pin_out;
            irq_o   <= 1'b1;
          end
        end else if (cnt_q == '0) begin
          cnt_q   <= rld_q;
          pin_out <= ~pin_out;
          irq_o   <= 1'b1;
        end else begin
          cnt_q <= cnt_q - 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/freq_div_chan_chk.sv
module freq_div_chan_chk (
  input logic clk,
  input logic rst_n,
  input logic start_tgl,
  input logic pin_out,
  input logic irq_o,
  input logic run_q,
  input logic armed_q
);

  p_toggle_irq_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_out != $past(pin_out)) |-> irq_o);

  p_irq_toggle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (pin_out != $past(pin_out)));

  p_hold_when_stopped_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !run_q |=> $stable(pin_out));

  p_irq_needs_run_r11: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> $past(run_q));

  p_load_edge_mode_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(!armed_q) && irq_o) |-> $past(start_tgl));

endmodule

bind freq_div_chan freq_div_chan_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start_tgl(start_tgl), .pin_out(pin_out),
  .irq_o(irq_o), .run_q(run_q), .armed_q(armed_q)
);

// File: tb/test_freq_div_chan.sv
`timescale 1ns/1ps
module test_freq_div_chan;
  localparam int W = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic pin_in = 1'b0, start_i = 1'b0, stop_i = 1'b0;
  logic [1:0] edge_sel = 2'b00;
  logic filt_en = 1'b0, start_tgl = 1'b0, rld_we = 1'b0;
  logic [W-1:0] rld_wdata = '0;
  logic pin_out, irq_o;

  always #2 clk = ~clk;

  freq_div_chan #(.W(W)) i_freq_div_chan (
    .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .start_i(start_i), .stop_i(stop_i),
    .edge_sel(edge_sel), .filt_en(filt_en), .start_tgl(start_tgl), .rld_we(rld_we),
    .rld_wdata(rld_wdata), .pin_out(pin_out), .irq_o(irq_o)
  );

  int n_chk = 0, n_bad = 0;
  int irq_seen = 0, irq_wide = 0;
  logic irq_prev = 1'b0;

  always @(posedge clk) begin
    if (rst_n && irq_o) begin
      irq_seen++;
      if (irq_prev) irq_wide++;
    end
    irq_prev = irq_o;
  end

  bit m_run = 0, m_arm = 0, m_out = 0, m_lvl = 0, m_tgl = 0, m_filt = 0;
  bit [1:0] m_mode = 0;
  int m_cnt = 0, m_rld = 0, m_irqs = 0;

  function automatic bit counts(bit newlvl);
    if (m_mode[1]) return 1'b1;
    if (m_mode[0]) return !newlvl;
    return newlvl;
  endfunction

  task automatic model_edge(bit newlvl);
    if (m_run && counts(newlvl)) begin
      if (!m_arm) begin
        m_arm = 1; m_cnt = m_rld;
        if (m_tgl) begin m_out = !m_out; m_irqs++; end
      end else if (m_cnt == 0) begin
        m_cnt = m_rld; m_out = !m_out; m_irqs++;
      end else m_cnt--;
    end
  endtask

  task automatic chk(string tag, int got, int exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic compare(string tag);
    chk(tag, pin_out, m_out);
    chk(tag, irq_seen, m_irqs);
    chk("R7", irq_wide, 0);
  endtask

  task automatic flip(string tag, int hold);
    @(negedge clk);
    pin_in = !m_lvl;
    repeat (hold) @(negedge clk);
    m_lvl = !m_lvl;
    model_edge(m_lvl);
    compare(tag);
  endtask

  task automatic glitch(string tag);
    @(negedge clk);
    pin_in = !m_lvl;
    @(negedge clk);
    pin_in = m_lvl;
    repeat (7) @(negedge clk);
    if (!m_filt) begin
      model_edge(!m_lvl);
      model_edge(m_lvl);
    end
    compare(tag);
  endtask

  task automatic write_rld(int v);
    @(negedge clk);
    rld_we = 1; rld_wdata = W'(v);
    @(negedge clk);
    rld_we = 0;
    m_rld = v;
  endtask

  task automatic set_cfg(bit [1:0] mode, bit tgl, bit filt);
    @(negedge clk);
    edge_sel = mode; start_tgl = tgl; filt_en = filt;
    m_mode = mode; m_tgl = tgl; m_filt = filt;
    repeat (4) @(negedge clk);
  endtask

  task automatic do_start;
    @(negedge clk); start_i = 1;
    @(negedge clk); start_i = 0;
    m_run = 1; m_arm = 0;
  endtask

  task automatic do_stop;
    @(negedge clk); stop_i = 1;
    @(negedge clk); stop_i = 0;
    m_run = 0;
  endtask

  initial begin
    #(4 * 200000);
    n_bad++; n_chk++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int seed;
    seed = $urandom(32'h5eed_1234);
    repeat (3) @(negedge clk);
    chk("R1", pin_out, 0);
    chk("R1", irq_o, 0);
    rst_n = 1;
    @(negedge clk);
    chk("R1", pin_out, 0);
    chk("R1", irq_o, 0);

    // R2: idle channel ignores edges
    for (int i = 0; i < 4; i++) flip("R2", 6);

    // R2 load edge without toggle, then R4 spacing
    write_rld(2);
    set_cfg(2'b00, 0, 0);
    do_start();
    flip("R2", 6); flip("R2", 6);
    for (int i = 0; i < 14; i++) flip("R4", 6);

    // R3 load edge with toggle
    do_stop();
    set_cfg(2'b00, 1, 0);
    do_start();
    if (m_lvl) flip("R3", 6);
    flip("R3", 6);
    for (int i = 0; i < 6; i++) flip("R4", 7);

    // R5 falling, R6 both
    do_stop();
    set_cfg(2'b01, 0, 0);
    write_rld(1);
    do_start();
    for (int i = 0; i < 12; i++) flip("R5", 6);
    do_stop();
    set_cfg(2'b10, 0, 1);
    do_start();
    for (int i = 0; i < 10; i++) flip("R6", 6);
    do_stop();
    set_cfg(2'b11, 1, 0);
    write_rld(0);
    do_start();
    for (int i = 0; i < 6; i++) flip("R6", 6);

    // R8 deferred reload
    do_stop();
    set_cfg(2'b10, 0, 0);
    write_rld(3);
    do_start();
    flip("R8", 6); flip("R8", 6);
    write_rld(1);
    for (int i = 0; i < 10; i++) flip("R8", 6);

    // R9 / R10 glitches, rising mode, reload 0
    do_stop();
    set_cfg(2'b00, 0, 1);
    write_rld(0);
    do_start();
    if (m_lvl) flip("R9", 6);
    flip("R9", 6);
    flip("R9", 6);
    glitch("R9"); glitch("R9");
    flip("R9", 6); flip("R9", 6);
    set_cfg(2'b00, 0, 0);
    glitch("R10"); glitch("R10");

    // R11 stop holds level, restart needs load edge
    do_stop();
    for (int i = 0; i < 6; i++) flip("R11", 6);
    do_start();
    for (int i = 0; i < 4; i++) flip("R11", 6);

    // random mix
    for (int r = 0; r < 9; r++) begin
      bit [1:0] md;
      string tg;
      md = 2'(r % 3);
      tg = (md == 0) ? "R4" : (md == 1) ? "R5" : "R6";
      do_stop();
      set_cfg(md, 1'($urandom % 2), 1'($urandom % 2));
      write_rld(int'($urandom % 5));
      do_start();
      for (int i = 0; i < 30; i++) begin
        if ($urandom % 10 == 0) write_rld(int'($urandom % 5));
        flip(tg, 6 + int'($urandom % 4));
      end
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule